// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns a 32-bit instruction word into the control signals of a single-cycle load/store datapath. It is purely combinational. A primary decode of the 6-bit opcode drives the register-file, memory and branch enables, and it also drives a 2-bit ALU class code. A secondary stage turns that class code into a 3-bit ALU operation. It reads the 6-bit function field only when the class code marks a register-register instruction.

The supported instructions are register-register add, subtract, and, or and set-on-less-than, plus load word, store word and branch-if-equal. Every other opcode, including the jump and branch-if-not-equal encodings, leaves all enables inactive. Every output that would otherwise be a don't-care is driven to 0, so each output has a defined value for every input word. The register selects, the ALU, the memories and the program counter sit outside the block.

Top module: `ctrl_decoder`

## Requirements
- R1: Opcode 0 (bits 31:26) gives reg_dst=1, reg_write=1, alu_op=2'b10, and alu_src, mem_to_reg, mem_read, mem_write and branch all 0.
- R2: Opcode 35 gives alu_src=1, mem_to_reg=1, reg_write=1, mem_read=1, reg_dst=0, mem_write=0, branch=0, alu_op=2'b00 and alu_ctl=3'b010.
- R3: Opcode 43 gives alu_src=1, mem_write=1, alu_op=2'b00 and alu_ctl=3'b010, with reg_dst, mem_to_reg, reg_write, mem_read and branch all 0.
- R4: Opcode 4 gives branch=1, alu_op=2'b01 and alu_ctl=3'b110, with every other enable 0.
- R5: Any other opcode, including 2, 3 and 5, drives all seven enables to 0, alu_op=2'b00 and alu_ctl=3'b010.
- R6: When alu_op is 2'b00 or 2'b01, the function field (bits 5:0) has no effect on alu_ctl.
- R7: With alu_op=2'b10, function 32 gives alu_ctl 3'b010, 34 gives 3'b110, 36 gives 3'b000, 37 gives 3'b001 and 42 gives 3'b111.
- R8: With alu_op=2'b10, any other function value gives alu_ctl 3'b000. The other outputs stay as in R1.
- R9: Bits 25:6 of the instruction have no effect on any output.
- R10: mem_write is never 1 together with reg_write or mem_read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being decoded |
| reg_dst | output | 1 | Destination register comes from bits 15:11 instead of 20:16 |
| alu_src | output | 1 | Second ALU operand is the sign-extended immediate |
| mem_to_reg | output | 1 | Register write data comes from data memory |
| reg_write | output | 1 | Register file write enable |
| mem_read | output | 1 | Data memory read enable |
| mem_write | output | 1 | Data memory write enable |
| branch | output | 1 | Conditional branch instruction |
| alu_op | output | 2 | ALU class code from the primary decode |
| alu_ctl | output | 3 | Final ALU operation |

## Verification
On every change of a known input word, the assertions check the structural rules. A store never also writes a register or reads memory. A load always routes memory data to a register write. A branch always subtracts without writing. Outside the register-register class the ALU operation is always add or subtract. Other facts need the bench's sweeps: the exact function-to-operation table, the all-zero result for the jump and unknown opcodes, and the fact that the register and shift fields are ignored. The bench sweeps all 64 opcodes, all 64 function codes and random middle fields.

// File: rtl/ctrl_decoder.sv
module ctrl_decoder (
  input  logic [31:0] instr,
  output logic        reg_dst,
  output logic        alu_src,
  output logic        mem_to_reg,
  output logic        reg_write,
  output logic        mem_read,
  output logic        mem_write,
  output logic        branch,
  output logic [1:0]  alu_op,
  output logic [2:0]  alu_ctl
);
  localparam logic [5:0] OP_REG   = 6'd0;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;
  localparam logic [5:0] OP_BEQ   = 6'd4;

  localparam logic [1:0] CLS_ADD = 2'b00;
  localparam logic [1:0] CLS_SUB = 2'b01;
  localparam logic [1:0] CLS_FN  = 2'b10;

  localparam logic [2:0] ALU_AND = 3'b000;
  localparam logic [2:0] ALU_OR  = 3'b001;
  localparam logic [2:0] ALU_ADD = 3'b010;
  localparam logic [2:0] ALU_SUB = 3'b110;
  localparam logic [2:0] ALU_SLT = 3'b111;

  logic [5:0] opcode, funct;
  assign opcode = instr[31:26];
  assign funct  = instr[5:0];

  always_comb begin
    reg_dst    = 1'b0;
    alu_src    = 1'b0;
    mem_to_reg = 1'b0;
    reg_write  = 1'b0;
    mem_read   = 1'b0;
    mem_write  = 1'b0;
    branch     = 1'b0;
    alu_op     = CLS_ADD;
    case (opcode)
      OP_REG: begin
        reg_dst   = 1'b1;
        reg_write = 1'b1;
        alu_op    = CLS_FN;
      end
      OP_LOAD: begin
        alu_src    = 1'b1;
        mem_to_reg = 1'b1;
        reg_write  = 1'b1;
        mem_read   = 1'b1;
      end
      OP_STORE: begin
        alu_src   = 1'b1;
        mem_write = 1'b1;
      end
      OP_BEQ: begin
        branch = 1'b1;
        alu_op = CLS_SUB;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (alu_op)
      CLS_ADD: alu_ctl = ALU_ADD;
      CLS_SUB: alu_ctl = ALU_SUB;
      CLS_FN: begin
        case (funct)
          6'd32:   alu_ctl = ALU_ADD;
          6'd34:   alu_ctl = ALU_SUB;
          6'd36:   alu_ctl = ALU_AND;
          6'd37:   alu_ctl = ALU_OR;
          6'd42:   alu_ctl = ALU_SLT;
          default: alu_ctl = ALU_AND;
        endcase
      end
      default: alu_ctl = ALU_AND;
    endcase
  end
endmodule

// File: rtl/ctrl_decoder_chk.sv
module ctrl_decoder_chk (
  input logic [31:0] instr,
  input logic        reg_dst,
  input logic        alu_src,
  input logic        mem_to_reg,
  input logic        reg_write,
  input logic        mem_read,
  input logic        mem_write,
  input logic        branch,
  input logic [1:0]  alu_op,
  input logic [2:0]  alu_ctl
);
  always_comb begin
    if (!$isunknown(instr)) begin
      AST_STORE_EXCL: assert (!(mem_write && (reg_write || mem_read))) else $error("store overlap"); // R10
      AST_LOAD_PATH: assert (!mem_read || (mem_to_reg && reg_write && alu_src && !reg_dst)) else $error("load path"); // R2
      AST_BRANCH_SUB: assert (!branch || (alu_ctl == 3'b110 && !reg_write && !mem_write)) else $error("branch"); // R4
      AST_FIXED_CLASS: assert (alu_op == 2'b10 || alu_ctl == 3'b010 || alu_ctl == 3'b110) else $error("class"); // R6
      AST_REG_CLASS: assert ((instr[31:26] != 6'd0) || (reg_dst && reg_write && alu_op == 2'b10)) else $error("reg class"); // R1
      AST_IDLE_OP: assert (!(instr[31:26] inside {6'd2, 6'd3, 6'd5}) ||
                           !(reg_write || mem_write || mem_read || branch)) else $error("idle"); // R5
    end
  end
endmodule

bind ctrl_decoder ctrl_decoder_chk chk (.*);

// File: tb/ctrl_decoder_test.sv
`timescale 1ns/1ps
module ctrl_decoder_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] instr;
  logic reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch;
  logic [1:0] alu_op;
  logic [2:0] alu_ctl;

  ctrl_decoder uut (.*);

  int checks = 0;
  int fails = 0;
  bit done = 0;

  function automatic logic [11:0] model(input logic [31:0] w);
    int op = int'(w[31:26]);
    int fn = int'(w[5:0]);
    logic [11:0] r;
    if (op == 0) begin
      r = {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 3'b000};
      if (fn == 32) r[2:0] = 3'b010;
      else if (fn == 34) r[2:0] = 3'b110;
      else if (fn == 37) r[2:0] = 3'b001;
      else if (fn == 42) r[2:0] = 3'b111;
    end else if (op == 35) r = 12'b0_1_1_1_1_0_0_00_010;
    else if (op == 43) r = 12'b0_1_0_0_0_1_0_00_010;
    else if (op == 4)  r = 12'b0_0_0_0_0_0_1_01_110;
    else               r = 12'b0_0_0_0_0_0_0_00_010;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] w);
    logic [11:0] exp, act;
    @(posedge clk);
    #1 instr = w;
    @(negedge clk);
    exp = model(w);
    act = {reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch, alu_op, alu_ctl};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s instr=%h actual=%b expected=%b", req, w, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int op, input int fn);
    return {op[5:0], 20'd0, fn[5:0]};
  endfunction

  initial begin
    instr = 32'd0;
    // reset-state style check: all-zero word is register-register with funct 0 (R8)
    check("R8", 32'd0);
    check("R1", mk(0, 32));
    check("R7", mk(0, 32));
    check("R7", mk(0, 34));
    check("R7", mk(0, 36));
    check("R7", mk(0, 37));
    check("R7", mk(0, 42));
    check("R2", mk(35, 0));
    check("R3", mk(43, 0));
    check("R4", mk(4, 0));
    check("R5", mk(2, 0));
    check("R5", mk(3, 0));
    check("R5", mk(5, 0));
    check("R5", mk(63, 42));
    for (int f = 0; f < 64; f++)
      check((f inside {32, 34, 36, 37, 42}) ? "R7" : "R8", mk(0, f));
    for (int f = 0; f < 64; f++) begin
      check("R6", mk(35, f));
      check("R6", mk(43, f));
      check("R6", mk(4, f));
    end
    for (int o = 0; o < 64; o++)
      check((o inside {0, 35, 43, 4}) ? "R1" : "R5", mk(o, o));
    for (int i = 0; i < 60; i++) begin
      logic [31:0] w;
      int ops[5] = '{0, 35, 43, 4, 2};
      int fns[3] = '{34, 42, 37};
      w = mk(ops[i % 5], fns[i % 3]);
      w[25:6] = $urandom();
      check("R9", w);
    end
    check("R10", mk(43, 37));
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule